// File: doc/BRIEF.md
# Watchdog interval timer

A peripheral for a small 16-bit microcontroller that runs a free counter and does one of two things when the selected period runs out. In watchdog mode, an expiry asks for a system reset. In interval mode, an expiry sets a sticky interrupt flag and the counter starts the next period at once. The block sits on a simple synchronous peripheral bus. Three addresses are decoded: a control register, an interrupt-enable register and an interrupt-flag register.

Changes to the control register are guarded by a key. A word write changes the stored control bits only when the key byte is in the upper half. Any other write to that address is treated as a fault and asks for a reset. Software restarts the count with a command bit that is never stored. It can freeze the count with a hold bit. The interrupt request is the AND of the enable and the flag. A CPU acknowledge of that request clears the flag.

Top module: `wdog_itimer`

## Requirements
- R1: After reset, the control register reads 0x6900 (watchdog mode, 32768 period, no hold), the enable (address 0x0000) and flag (address 0x0002) registers read 0, and irq_req and rst_req are low.
- R2: A write to address 0x0120 with both byte strobes set and 0x5A in bits [15:8] stores bits [7:4] and [2:0] of the write data. A read of 0x0120 returns 0x69 in bits [15:8], the stored bits in [7:4] and [2:0], and 0 in bit 3.
- R3: A write to 0x0120 that has a wrong upper byte, or that sets only one byte strobe, leaves the control bits unchanged. It raises rst_req for exactly the one cycle after the write.
- R4: Control bits [1:0] give the period P in clocks: 11 gives 64, 10 gives 512, 01 gives 8192, 00 gives 32768. After a control write that clears the counter, the expiry takes effect P clock edges after the write edge.
- R5: A keyed write with bit 3 set restarts the count from zero. Bit 3 is not stored.
- R6: With bit 4 set (interval mode), an expiry sets flag bit 0 and does not raise rst_req. With bit 4 clear (watchdog mode), an expiry raises rst_req for one cycle and leaves the flag unchanged.
- R7: While bit 7 is set, the count stays frozen and no expiry occurs. When bit 7 is cleared, counting resumes from the frozen value.
- R8: The flag stays set until it is cleared, whatever the enable bit holds. A write with the low byte strobe to 0x0002 loads bit 0 of the write data into the flag.
- R9: irq_req is high exactly when enable bit 0 (written with the low byte strobe to 0x0000) and the flag are both set.
- R10: An irq_ack pulse clears the flag, so irq_req drops in the next cycle.
- R11: After an expiry the count starts again from zero, and another expiry follows P cycles later without further writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Peripheral byte address |
| bus_wdata | input | 16 | Write data |
| bus_wen | input | 2 | Byte write strobes: bit 0 for the low byte, bit 1 for the high byte |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid in the same cycle as bus_ren; zero when no read or no decoded address |
| irq_ack | input | 1 | CPU acknowledge of the watchdog interrupt |
| irq_req | output | 1 | Interrupt request (enable AND flag) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest situations to reach are a restart or a freeze in the middle of a period. Neither is visible at the ports until the expiry turns up early or late. The stimulus clears the counter, lets it run a known number of cycles, and then issues a second clear or a hold. After releasing the hold, it samples the flag one cycle before and one cycle at the moment the remaining count predicts. A premature or missing expiry therefore shows up as a wrong flag value on a single named cycle. Back-to-back expiries with an acknowledge in between show that the count restarts after each expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam logic [15:0] WDOG_ADDR_IE   = 16'h0000;
    localparam logic [15:0] WDOG_ADDR_IFG  = 16'h0002;
    localparam logic [15:0] WDOG_ADDR_CTRL = 16'h0120;

    localparam logic [7:0]  WDOG_WR_KEY    = 8'h5A;
    localparam logic [7:0]  WDOG_RD_TAG    = 8'h69;

    localparam int          WDOG_NUM_SEL   = 4;

    // stored control bits (bit 3 of the bus byte is a command, not stored)
    typedef struct packed {
        logic       hold;
        logic [1:0] spare_hi;
        logic       intv;
        logic       spare_lo;
        logic [1:0] sel;
    } wdog_ctrl_t;

    typedef struct packed {
        wdog_ctrl_t ctrl;
        logic       rst_req;
    } wdog_cregs_t;

    typedef struct packed {
        logic ie;
        logic ifg;
    } wdog_iregs_t;

    function automatic logic [7:0] wdog_ctrl_byte(input wdog_ctrl_t c);
        return {c.hold, c.spare_hi, c.intv, 1'b0, c.spare_lo, c.sel};
    endfunction

endpackage

// File: rtl/wdog_bus_dec.sv
module wdog_bus_dec
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        key_byte,
    input  logic [1:0]        bus_wen,
    input  logic              bus_ren,
    input  wdog_ctrl_t        ctrl,
    input  logic              ie,
    input  logic              ifg,
    output logic              ctrl_wr_ok,
    output logic              ctrl_wr_bad,
    output logic              ie_wr,
    output logic              ifg_wr,
    output logic [15:0]       bus_rdata
);

    logic hit_ctrl;
    logic hit_ie;
    logic hit_ifg;
    logic key_ok;

    always_comb begin
        hit_ctrl    = (bus_addr == ADDR_W'(WDOG_ADDR_CTRL));
        hit_ie      = (bus_addr == ADDR_W'(WDOG_ADDR_IE));
        hit_ifg     = (bus_addr == ADDR_W'(WDOG_ADDR_IFG));
        key_ok      = (bus_wen == 2'b11) && (key_byte == WDOG_WR_KEY);

        ctrl_wr_ok  = hit_ctrl && key_ok;
        ctrl_wr_bad = hit_ctrl && (|bus_wen) && !key_ok;
        ie_wr       = hit_ie  && bus_wen[0];
        ifg_wr      = hit_ifg && bus_wen[0];

        bus_rdata = '0;
        if (bus_ren) begin
            if (hit_ctrl) begin
                bus_rdata = {WDOG_RD_TAG, wdog_ctrl_byte(ctrl)};
            end else if (hit_ie) begin
                bus_rdata = {15'b0, ie};
            end else if (hit_ifg) begin
                bus_rdata = {15'b0, ifg};
            end
        end
    end

endmodule

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ok,
    input  logic       wr_bad,
    input  logic [7:0] wr_byte,
    input  logic       expire,
    output wdog_ctrl_t ctrl,
    output logic       clr_cmd,
    output logic       rst_req
);

    wdog_cregs_t cr_d, cr_q;

    always_comb begin
        cr_d    = cr_q;
        clr_cmd = wr_ok && wr_byte[3];
        if (wr_ok) begin
            cr_d.ctrl = wdog_ctrl_t'({wr_byte[7:4], wr_byte[2:0]});
        end
        // fault write, or expiry while in watchdog mode
        cr_d.rst_req = wr_bad || (expire && !cr_q.ctrl.intv);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cr_q <= '0;
        end else begin
            cr_q <= cr_d;
        end
    end

    assign ctrl    = cr_q.ctrl;
    assign rst_req = cr_q.rst_req;

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CNT_W     = 15,
    parameter int SEL0_LOG2 = 15,
    parameter int SEL1_LOG2 = 13,
    parameter int SEL2_LOG2 = 9,
    parameter int SEL3_LOG2 = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic             hold,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    localparam int LOGS [WDOG_NUM_SEL] = '{SEL0_LOG2, SEL1_LOG2, SEL2_LOG2, SEL3_LOG2};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t        cs_d, cs_q;
    logic [CNT_W-1:0] lim_tab [WDOG_NUM_SEL];
    logic [CNT_W-1:0] limit;

    for (genvar gi = 0; gi < WDOG_NUM_SEL; gi++) begin : g_lim
        assign lim_tab[gi] = CNT_W'((64'd1 << LOGS[gi]) - 64'd1);
    end

    always_comb begin
        cs_d   = cs_q;
        limit  = lim_tab[sel];
        // >= keeps a shortened period from missing its terminal value
        expire = !hold && !clr && (cs_q.cnt >= limit);
        if (clr) begin
            cs_d.cnt = '0;
        end else if (hold) begin
            cs_d.cnt = cs_q.cnt;
        end else if (expire) begin
            cs_d.cnt = '0;
        end else begin
            cs_d.cnt = cs_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign cnt = cs_q.cnt;

endmodule

// File: rtl/wdog_intr.sv
module wdog_intr
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic intv,
    input  logic ie_wr,
    input  logic ifg_wr,
    input  logic wbit,
    input  logic irq_ack,
    output logic ie,
    output logic ifg,
    output logic irq_req
);

    wdog_iregs_t iq_d, iq_q;

    always_comb begin
        iq_d = iq_q;
        if (ie_wr) begin
            iq_d.ie = wbit;
        end
        if (ifg_wr) begin
            iq_d.ifg = wbit;
        end
        if (irq_ack) begin
            iq_d.ifg = 1'b0;
        end
        // a new expiry wins over any clear in the same cycle
        if (expire && intv) begin
            iq_d.ifg = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iq_q <= '0;
        end else begin
            iq_q <= iq_d;
        end
    end

    assign ie      = iq_q.ie;
    assign ifg     = iq_q.ifg;
    assign irq_req = iq_q.ie && iq_q.ifg;

endmodule

// File: rtl/wdog_itimer.sv
module wdog_itimer
    import wdog_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SEL0_LOG2 = 15,
    parameter int SEL1_LOG2 = 13,
    parameter int SEL2_LOG2 = 9,
    parameter int SEL3_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic [1:0]        bus_wen,
    input  logic              bus_ren,
    output logic [15:0]       bus_rdata,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic              rst_req
);

    localparam int MAX_A = (SEL0_LOG2 > SEL1_LOG2) ? SEL0_LOG2 : SEL1_LOG2;
    localparam int MAX_B = (SEL2_LOG2 > SEL3_LOG2) ? SEL2_LOG2 : SEL3_LOG2;
    localparam int CNT_W = (MAX_A > MAX_B) ? MAX_A : MAX_B;

    wdog_ctrl_t       ctrl_q;
    logic             ctrl_wr_ok;
    logic             ctrl_wr_bad;
    logic             ie_wr;
    logic             ifg_wr;
    logic             clr_cmd;
    logic             expire;
    logic [CNT_W-1:0] cnt_w;
    logic             ie_w;
    logic             ifg_w;
    logic             intv_w;
    logic             hold_w;

    assign intv_w = ctrl_q.intv;
    assign hold_w = ctrl_q.hold;

    wdog_bus_dec #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .bus_addr    (bus_addr),
        .key_byte    (bus_wdata[15:8]),
        .bus_wen     (bus_wen),
        .bus_ren     (bus_ren),
        .ctrl        (ctrl_q),
        .ie          (ie_w),
        .ifg         (ifg_w),
        .ctrl_wr_ok  (ctrl_wr_ok),
        .ctrl_wr_bad (ctrl_wr_bad),
        .ie_wr       (ie_wr),
        .ifg_wr      (ifg_wr),
        .bus_rdata   (bus_rdata)
    );

    wdog_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (ctrl_wr_ok),
        .wr_bad  (ctrl_wr_bad),
        .wr_byte (bus_wdata[7:0]),
        .expire  (expire),
        .ctrl    (ctrl_q),
        .clr_cmd (clr_cmd),
        .rst_req (rst_req)
    );

    wdog_counter #(
        .CNT_W     (CNT_W),
        .SEL0_LOG2 (SEL0_LOG2),
        .SEL1_LOG2 (SEL1_LOG2),
        .SEL2_LOG2 (SEL2_LOG2),
        .SEL3_LOG2 (SEL3_LOG2)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (ctrl_q.sel),
        .hold   (hold_w),
        .clr    (clr_cmd),
        .cnt    (cnt_w),
        .expire (expire)
    );

    wdog_intr u_intr (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .intv    (intv_w),
        .ie_wr   (ie_wr),
        .ifg_wr  (ifg_wr),
        .wbit    (bus_wdata[0]),
        .irq_ack (irq_ack),
        .ie      (ie_w),
        .ifg     (ifg_w),
        .irq_req (irq_req)
    );

endmodule

// File: rtl/wdog_itimer_chk.sv
module wdog_itimer_chk
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        wkey,
    input logic              wbit0,
    input logic [1:0]        bus_wen,
    input logic              bus_ren,
    input logic [15:0]       bus_rdata,
    input logic              irq_ack,
    input logic              irq_req,
    input logic              rst_req,
    input logic              expire,
    input logic              intv,
    input logic              hold,
    input logic              clr_cmd,
    input logic              ifg,
    input logic [CNT_W-1:0]  cnt
);

    logic bad_wr;
    logic flag_wr;
    logic ctrl_rd;

    always_comb begin
        bad_wr  = (bus_addr == ADDR_W'(WDOG_ADDR_CTRL)) && (|bus_wen) &&
                  !((bus_wen == 2'b11) && (wkey == WDOG_WR_KEY));
        flag_wr = (bus_addr == ADDR_W'(WDOG_ADDR_IFG)) && bus_wen[0];
        ctrl_rd = bus_ren && (bus_addr == ADDR_W'(WDOG_ADDR_CTRL));
    end

    a_r2_read_tag: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd |-> (bus_rdata[15:8] == WDOG_RD_TAG) && !bus_rdata[3]);

    a_r3_bad_key_reset: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> rst_req);

    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> (cnt == '0));

    a_r6_interval_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && intv && !bad_wr) |=> !rst_req);

    a_r6_reset_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !bad_wr && !expire) |=> !rst_req);

    a_r7_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr_cmd) |=> (cnt == $past(cnt)));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ifg && !irq_ack && !flag_wr) |=> ifg);

    a_r8_flag_write: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !irq_ack && !(expire && intv)) |=> (ifg == $past(wbit0)));

    a_r10_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !(expire && intv)) |=> !irq_req);

endmodule

bind wdog_itimer wdog_itimer_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .wkey      (bus_wdata[15:8]),
    .wbit0     (bus_wdata[0]),
    .bus_wen   (bus_wen),
    .bus_ren   (bus_ren),
    .bus_rdata (bus_rdata),
    .irq_ack   (irq_ack),
    .irq_req   (irq_req),
    .rst_req   (rst_req),
    .expire    (expire),
    .intv      (intv_w),
    .hold      (hold_w),
    .clr_cmd   (clr_cmd),
    .ifg       (ifg_w),
    .cnt       (cnt_w)
);

// File: tb/wdog_itimer_tb.sv
module wdog_itimer_tb;

    localparam logic [15:0] A_CTRL = 16'h0120;
    localparam logic [15:0] A_IE   = 16'h0000;
    localparam logic [15:0] A_IFG  = 16'h0002;
    localparam int K_RD  = 0;
    localparam int K_IRQ = 1;
    localparam int K_RST = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [1:0]  bus_wen;
    logic        bus_ren;
    logic [15:0] bus_rdata;
    logic        irq_ack;
    logic        irq_req;
    logic        rst_req;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    typedef struct {
        int          kind;
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t exp_q[$];
    event  smp_ev;

    always #10 clk = ~clk;

    wdog_itimer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wen   (bus_wen),
        .bus_ren   (bus_ren),
        .bus_rdata (bus_rdata),
        .irq_ack   (irq_ack),
        .irq_req   (irq_req),
        .rst_req   (rst_req)
    );

    // monitor: pops the expected item and compares when the driver signals
    initial begin
        forever begin
            item_t       it;
            logic [15:0] act;
            @(smp_ev);
            #1;
            it = exp_q.pop_front();
            case (it.kind)
                K_RD:    act = bus_rdata;
                K_IRQ:   act = {15'b0, irq_req};
                default: act = {15'b0, rst_req};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s kind=%0d actual=%h expected=%h at %0t",
                         it.req, it.kind, act, it.exp, $time);
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic [1:0] we);
        bus_addr  = a;
        bus_wdata = d;
        bus_wen   = we;
        @(negedge clk);
        bus_wen   = 2'b00;
        bus_addr  = '0;
        bus_wdata = '0;
    endtask

    task automatic chk(input int kind, input logic [15:0] a, input logic [15:0] e, input string req);
        item_t it;
        it.kind = kind;
        it.exp  = e;
        it.req  = req;
        exp_q.push_back(it);
        if (kind == K_RD) begin
            bus_addr = a;
            bus_ren  = 1'b1;
        end
        -> smp_ev;
        #2;
        bus_ren  = 1'b0;
        bus_addr = '0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n     = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        bus_wen   = 2'b00;
        bus_ren   = 1'b0;
        irq_ack   = 1'b0;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        chk(K_RD, A_CTRL, 16'h6900, "R1");
        chk(K_RD, A_IE, 16'h0000, "R1");
        chk(K_RD, A_IFG, 16'h0000, "R1");
        chk(K_IRQ, '0, 16'h0000, "R1");
        chk(K_RST, '0, 16'h0000, "R1");

        // R2 keyed writes, read-back format
        wr(A_CTRL, 16'h5AFF, 2'b11);
        chk(K_RD, A_CTRL, 16'h69F7, "R2");
        wr(A_CTRL, 16'h5A55, 2'b11);
        chk(K_RD, A_CTRL, 16'h6955, "R2");
        wr(A_CTRL, 16'h5AAA, 2'b11);
        chk(K_RD, A_CTRL, 16'h69A2, "R2");

        // R3 wrong key, then byte-only write
        wr(A_CTRL, 16'h1280, 2'b11);
        chk(K_RST, '0, 16'h0001, "R3");
        chk(K_RD, A_CTRL, 16'h69A2, "R3");
        wait_n(1);
        chk(K_RST, '0, 16'h0000, "R3");
        wr(A_CTRL, 16'h5A13, 2'b01);
        chk(K_RST, '0, 16'h0001, "R3");
        chk(K_RD, A_CTRL, 16'h69A2, "R3");
        wait_n(1);
        chk(K_RST, '0, 16'h0000, "R3");

        // R4/R6 interval mode, period 64
        wr(A_CTRL, 16'h5A1B, 2'b11);
        wait_n(63);
        chk(K_RD, A_IFG, 16'h0000, "R4");
        wait_n(1);
        chk(K_RD, A_IFG, 16'h0001, "R4");
        chk(K_RST, '0, 16'h0000, "R6");
        chk(K_IRQ, '0, 16'h0000, "R9");

        // R8 flag sticks with enable off, cleared by byte write
        wait_n(10);
        chk(K_RD, A_IFG, 16'h0001, "R8");
        wr(A_IFG, 16'h0000, 2'b01);
        chk(K_RD, A_IFG, 16'h0000, "R8");

        // R9/R10/R11 enable, acknowledge, next period
        wr(A_IE, 16'h0001, 2'b01);
        chk(K_RD, A_IE, 16'h0001, "R9");
        wr(A_CTRL, 16'h5A1B, 2'b11);
        wait_n(63);
        chk(K_IRQ, '0, 16'h0000, "R9");
        wait_n(1);
        chk(K_IRQ, '0, 16'h0001, "R9");
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk(K_IRQ, '0, 16'h0000, "R10");
        chk(K_RD, A_IFG, 16'h0000, "R10");
        wait_n(62);
        chk(K_IRQ, '0, 16'h0000, "R11");
        wait_n(1);
        chk(K_IRQ, '0, 16'h0001, "R11");
        wr(A_IE, 16'h0000, 2'b01);
        chk(K_IRQ, '0, 16'h0000, "R9");
        wr(A_IFG, 16'h0000, 2'b01);

        // R5 restart mid-period
        wr(A_CTRL, 16'h5A1B, 2'b11);
        wait_n(39);
        wr(A_CTRL, 16'h5A1B, 2'b11);
        wait_n(63);
        chk(K_RD, A_IFG, 16'h0000, "R5");
        wait_n(1);
        chk(K_RD, A_IFG, 16'h0001, "R5");
        chk(K_RD, A_CTRL, 16'h6913, "R5");
        wr(A_IFG, 16'h0000, 2'b01);

        // R7 hold after 20 counts, resume for the remaining 44
        wr(A_CTRL, 16'h5A1B, 2'b11);
        wait_n(19);
        wr(A_CTRL, 16'h5A93, 2'b11);
        wait_n(300);
        chk(K_RD, A_IFG, 16'h0000, "R7");
        chk(K_RD, A_CTRL, 16'h6993, "R7");
        wr(A_CTRL, 16'h5A13, 2'b11);
        wait_n(43);
        chk(K_RD, A_IFG, 16'h0000, "R7");
        wait_n(1);
        chk(K_RD, A_IFG, 16'h0001, "R7");
        wr(A_IFG, 16'h0000, 2'b01);

        // R4 period 512
        wr(A_CTRL, 16'h5A1A, 2'b11);
        wait_n(511);
        chk(K_RD, A_IFG, 16'h0000, "R4");
        wait_n(1);
        chk(K_RD, A_IFG, 16'h0001, "R4");
        wr(A_IFG, 16'h0000, 2'b01);

        // R4 period 8192
        wr(A_CTRL, 16'h5A19, 2'b11);
        wait_n(8191);
        chk(K_RD, A_IFG, 16'h0000, "R4");
        wait_n(1);
        chk(K_RD, A_IFG, 16'h0001, "R4");
        wr(A_IFG, 16'h0000, 2'b01);

        // R6/R11 watchdog mode, period 64, two expiries
        wr(A_CTRL, 16'h5A0B, 2'b11);
        wait_n(63);
        chk(K_RST, '0, 16'h0000, "R6");
        wait_n(1);
        chk(K_RST, '0, 16'h0001, "R6");
        chk(K_RD, A_IFG, 16'h0000, "R6");
        wait_n(1);
        chk(K_RST, '0, 16'h0000, "R6");
        wait_n(62);
        chk(K_RST, '0, 16'h0000, "R11");
        wait_n(1);
        chk(K_RST, '0, 16'h0001, "R11");

        // R4 period 32768 in watchdog mode
        wr(A_CTRL, 16'h5A08, 2'b11);
        wait_n(32767);
        chk(K_RST, '0, 16'h0000, "R4");
        wait_n(1);
        chk(K_RST, '0, 16'h0001, "R4");
        wait_n(1);
        chk(K_RST, '0, 16'h0000, "R4");

        wait_n(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired before the sequence ended");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule